// File: doc/BRIEF.md
# Debug Variable Capture Unit

This block is placed in the path of one monitored design signal so that a debugger can observe and change that signal while the design keeps running. The design signal enters on `sig_in` and leaves on `sig_out`. Normally the value passes straight through. A host can stage an override value, which the design then receives in place of its own value for exactly one enabled cycle.

On every enabled cycle selected by a programmable sampling period, the value on `sig_out` is recorded into a power-of-two circular history RAM. The same value is pushed into a drain FIFO, which streams samples out through a valid/ready port towards deeper storage. A stall request warns the surrounding clock control before the FIFO overflows. Through a small request/response port, the host can read the live value or rewind into the history by an offset. One unit is instantiated per tracked variable, for example for every state register of a state machine.

Top module: `dbg_var_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `host_rvalid`, `drain_valid` and `stall_req` are 0 and `sig_out` equals `sig_in`.
- R2: With no override pending, `sig_out` equals `sig_in` in the same cycle.
- R3: A host request with op 2'b01 stages `host_wdata` as an override. From the next cycle, `sig_out` carries that value, up to and including the first later cycle with `run_en`=1, and then returns to `sig_in`. A newer write replaces a staged value.
- R4: A request with op 2'b00 gives `host_rvalid`=1, `host_err`=0 on the next cycle, with `host_rdata` equal to `sig_out` in the request cycle. Ops 2'b01 and 2'b11, and cycles without a request, give `host_rvalid`=0.
- R5: Captures happen only on cycles with `run_en`=1. With period P = `cfg_every`+1, a capture happens on every P-th enabled cycle, starting with the first enabled cycle after reset. Cycles with `run_en`=0 do not advance the count. The value captured is `sig_out`.
- R6: A request with op 2'b10 and offset k = `host_addr` gives, on the next cycle, `host_rvalid`=1, `host_err`=0 and the value captured k captures before the newest one (k=0 is the newest), counting only captures made before the request cycle.
- R7: A rewind with k not below the number of valid entries (the number of captures, saturating at `HIST_DEPTH`) gives `host_err`=1 and `host_rdata`=0.
- R8: Captured samples leave on the drain port in capture order. A sample is taken when `drain_valid` and `drain_ready` are both 1. While a sample is not taken, `drain_data` holds. A capture that finds the FIFO holding `FIFO_DEPTH` samples is not queued.
- R9: On each cycle, `stall_req` is 1 exactly when the FIFO fill level, updated at the last clock edge, is at or above `cfg_hwm`.
- R10: A request with op 2'b11 changes nothing: it gives no response, stages no override and leaves history and FIFO untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Design clock enable; marks an enabled cycle |
| sig_in | input | DATA_W | Value produced by the design |
| sig_out | output | DATA_W | Value handed on to the design |
| cfg_every | input | DIV_W | Sampling period minus one |
| cfg_hwm | input | FLW | FIFO high-water mark for the stall request |
| host_valid | input | 1 | Host request strobe |
| host_op | input | 2 | 00 read live, 01 write override, 10 rewind, 11 no operation |
| host_addr | input | HA+1 | Rewind offset k |
| host_wdata | input | DATA_W | Override value |
| host_rvalid | output | 1 | Response valid, one cycle after a read or rewind |
| host_rdata | output | DATA_W | Response data |
| host_err | output | 1 | Rewind offset out of range |
| drain_valid | output | 1 | Drain FIFO holds a sample |
| drain_data | output | DATA_W | Oldest queued sample |
| drain_ready | input | 1 | Downstream takes the sample |
| stall_req | output | 1 | FIFO fill level at or above the high-water mark |

## Verification
`sig_out` is combinational and is checked in the same cycle its inputs are driven, before the edge. Responses, the drain outputs and `stall_req` are each due one edge after the request, capture or pop that caused them. Inputs are driven at the falling edge. The bench advances a reference model over exactly one rising edge, then compares all registered outputs at the next falling edge. Each expected value is therefore sampled exactly one register stage after its cause. The model decides captures, rewinds and pops from its own state as it stands before that edge.

// File: rtl/dvu_pkg.sv
package dvu_pkg;
  typedef enum logic [1:0] {
    OP_RDCUR  = 2'b00,
    OP_WRITE  = 2'b01,
    OP_REWIND = 2'b10,
    OP_NOP    = 2'b11
  } host_op_e;
endpackage

// File: rtl/dvu_sampler.sv
module dvu_sampler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] cfg_every,
  output logic             fire
);
  logic [DIV_W-1:0] phase_q, phase_d;

  assign fire = run_en && (phase_q == '0);

  always_comb begin
    phase_d = phase_q;
    if (run_en) begin
      if (phase_q >= cfg_every) phase_d = '0;
      else                      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/dvu_hist.sv
module dvu_hist #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int HA = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [HA:0]       rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [HA-1:0]     wptr_q, wptr_d, rd_idx;
  logic [HA:0]       cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (wr_en) begin
      wptr_d = wptr_q + 1'b1;
      if (cnt_q != (HA+1)'(DEPTH)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  assign rd_idx  = wptr_q - 1'b1 - rd_off[HA-1:0];
  assign rd_err  = (rd_off >= cnt_q);
  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dvu_fifo.sv
module dvu_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int FA  = $clog2(DEPTH),
  localparam int FLW = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [FLW-1:0]    level_nxt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [FA-1:0]     rp_q, wp_q, rp_d, wp_d;
  logic [FLW-1:0]    lvl_q;
  logic              do_push, do_pop;

  assign do_push   = push && (lvl_q < FLW'(DEPTH));
  assign do_pop    = pop_ready && (lvl_q != '0);
  assign out_valid = (lvl_q != '0);
  assign out_data  = mem[rp_q];

  always_comb begin
    rp_d      = do_pop  ? rp_q + 1'b1 : rp_q;
    wp_d      = do_push ? wp_q + 1'b1 : wp_q;
    level_nxt = lvl_q + FLW'(do_push) - FLW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      lvl_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      lvl_q <= level_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end
endmodule

// File: rtl/dbg_var_unit.sv
module dbg_var_unit
  import dvu_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int HIST_DEPTH = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  localparam int HA  = $clog2(HIST_DEPTH),
  localparam int FLW = $clog2(FIFO_DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [DATA_W-1:0] sig_in,
  output logic [DATA_W-1:0] sig_out,
  input  logic [DIV_W-1:0]  cfg_every,
  input  logic [FLW-1:0]    cfg_hwm,
  input  logic              host_valid,
  input  logic [1:0]        host_op,
  input  logic [HA:0]       host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_err,
  output logic              drain_valid,
  output logic [DATA_W-1:0] drain_data,
  input  logic              drain_ready,
  output logic              stall_req
);
  host_op_e          op;
  logic              is_wr, is_rd, is_rw, fire;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] ovr_q, ovr_d;
  logic              rv_d, err_d;
  logic [DATA_W-1:0] rdata_d, hist_data;
  logic              hist_err;
  logic [FLW-1:0]    lvl_nxt;
  logic              stall_d;

  assign op    = host_op_e'(host_op);
  assign is_wr = host_valid && (op == OP_WRITE);
  assign is_rd = host_valid && (op == OP_RDCUR);
  assign is_rw = host_valid && (op == OP_REWIND);

  assign sig_out = pend_q ? ovr_q : sig_in;

  dvu_sampler #(.DIV_W(DIV_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .cfg_every(cfg_every), .fire(fire)
  );

  dvu_hist #(.DATA_W(DATA_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(fire), .wr_data(sig_out),
    .rd_off(host_addr), .rd_data(hist_data), .rd_err(hist_err)
  );

  dvu_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fire), .push_data(sig_out),
    .pop_ready(drain_ready), .out_valid(drain_valid),
    .out_data(drain_data), .level_nxt(lvl_nxt)
  );

  always_comb begin
    pend_d = pend_q;
    ovr_d  = ovr_q;
    if (is_wr) begin
      pend_d = 1'b1;
      ovr_d  = host_wdata;
    end else if (run_en) begin
      pend_d = 1'b0;
    end
    rv_d    = is_rd || is_rw;
    err_d   = is_rw && hist_err;
    if (is_rd)         rdata_d = sig_out;
    else if (hist_err) rdata_d = '0;
    else               rdata_d = hist_data;
    stall_d = (lvl_nxt >= cfg_hwm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      host_rvalid <= 1'b0;
      host_err    <= 1'b0;
      stall_req   <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      host_rvalid <= rv_d;
      host_err    <= err_d;
      stall_req   <= stall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q      <= '0;
      host_rdata <= '0;
    end else begin
      if (is_wr) ovr_q      <= ovr_d;
      if (rv_d)  host_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/dvu_checker.sv
module dvu_checker #(
  parameter int DATA_W     = 16,
  parameter int HIST_DEPTH = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  localparam int HA = $clog2(HIST_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic [DATA_W-1:0] sig_in,
  input logic [DATA_W-1:0] sig_out,
  input logic              host_valid,
  input logic [1:0]        host_op,
  input logic [HA:0]       host_addr,
  input logic              host_rvalid,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_err,
  input logic              drain_valid,
  input logic [DATA_W-1:0] drain_data,
  input logic              drain_ready
);
  a_r4_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_op == 2'b00 |=> host_rvalid && !host_err);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |=> !host_rvalid);

  a_r7_rewind_oob: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_op == 2'b10 && int'(host_addr) >= HIST_DEPTH
    |=> host_err && host_rdata == '0);

  a_r3_oneshot_ends: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !(host_valid && host_op == 2'b01) |=> sig_out == sig_in);

  a_r8_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid && !drain_ready |=> drain_valid && $stable(drain_data));

  a_r10_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_op == 2'b11 |=> !host_rvalid);
endmodule

bind dbg_var_unit dvu_checker #(
  .DATA_W(DATA_W), .HIST_DEPTH(HIST_DEPTH),
  .FIFO_DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .sig_in(sig_in),
  .sig_out(sig_out), .host_valid(host_valid), .host_op(host_op),
  .host_addr(host_addr), .host_rvalid(host_rvalid),
  .host_rdata(host_rdata), .host_err(host_err),
  .drain_valid(drain_valid), .drain_data(drain_data),
  .drain_ready(drain_ready)
);

// File: tb/tb_dbg_var_unit.sv
module tb_dbg_var_unit;
  localparam int DW = 16, HD = 16, FD = 8, DV = 8;
  localparam int HA = $clog2(HD), FLW = $clog2(FD+1);

  logic clk = 1'b0;
  logic rst_n;
  logic run_en, host_valid, drain_ready;
  logic [DW-1:0] sig_in, host_wdata;
  logic [DV-1:0] cfg_every;
  logic [FLW-1:0] cfg_hwm;
  logic [1:0] host_op;
  logic [HA:0] host_addr;
  logic [DW-1:0] sig_out, host_rdata, drain_data;
  logic host_rvalid, host_err, drain_valid, stall_req;

  always #2 clk = ~clk;

  dbg_var_unit #(.DATA_W(DW), .HIST_DEPTH(HD), .FIFO_DEPTH(FD), .DIV_W(DV)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .sig_in(sig_in), .sig_out(sig_out),
    .cfg_every(cfg_every), .cfg_hwm(cfg_hwm), .host_valid(host_valid),
    .host_op(host_op), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .host_err(host_err),
    .drain_valid(drain_valid), .drain_data(drain_data),
    .drain_ready(drain_ready), .stall_req(stall_req));

  int checks = 0, fails = 0;
  // reference model state
  logic [DW-1:0] m_hist [HD];
  int m_wp = 0, m_cnt = 0, m_phase = 0;
  logic m_pend = 1'b0;
  logic [DW-1:0] m_ovr = '0;
  logic [DW-1:0] m_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_out();
    return m_pend ? m_ovr : sig_in;
  endfunction

  // one cycle: inputs already applied at a falling edge
  task automatic step();
    logic [DW-1:0] o, e_rd;
    bit e_rv, e_err, fire, is_wr;
    int pre, idx, hwm;
    #1;
    o = exp_out();
    chk(sig_out == o, m_pend ? "R3" : "R2", sig_out, o);
    e_rv = 0; e_err = 0; e_rd = '0;
    is_wr = host_valid && host_op == 2'b01;
    if (host_valid && host_op == 2'b00) begin e_rv = 1; e_rd = o; end
    if (host_valid && host_op == 2'b10) begin
      e_rv = 1;
      if (int'(host_addr) < m_cnt) begin
        idx = ((m_wp - 1 - int'(host_addr)) % HD + HD) % HD;
        e_rd = m_hist[idx];
      end else e_err = 1;
    end
    fire = run_en && m_phase == 0;
    if (run_en) m_phase = (m_phase >= int'(cfg_every)) ? 0 : m_phase + 1;
    pre = m_q.size();
    if (drain_ready && pre > 0) void'(m_q.pop_front());
    if (fire) begin
      m_hist[m_wp] = o;
      m_wp = (m_wp + 1) % HD;
      if (m_cnt < HD) m_cnt++;
      if (pre < FD) m_q.push_back(o);
    end
    if (is_wr) begin m_pend = 1; m_ovr = host_wdata; end
    else if (run_en) m_pend = 0;
    hwm = int'(cfg_hwm);
    @(posedge clk);
    @(negedge clk);
    chk(host_rvalid == e_rv, (host_valid && host_op == 2'b11) ? "R10" : "R4",
        host_rvalid, e_rv);
    if (e_rv) begin
      chk(host_rdata == e_rd, host_op == 2'b00 ? "R4" : (e_err ? "R7" : "R6"),
          host_rdata, e_rd);
      chk(host_err == e_err, "R7", host_err, e_err);
    end
    chk(drain_valid == (m_q.size() > 0), "R8", drain_valid, m_q.size() > 0);
    if (m_q.size() > 0) chk(drain_data == m_q[0], "R5 R8", drain_data, m_q[0]);
    chk(stall_req == (m_q.size() >= hwm), "R9", stall_req, m_q.size() >= hwm);
  endtask

  task automatic idle_in();
    host_valid = 0; host_op = 2'b11; host_addr = '0; host_wdata = '0;
  endtask

  task automatic host(input logic [1:0] op, input int a, input logic [DW-1:0] wd);
    host_valid = 1; host_op = op; host_addr = (HA+1)'(a); host_wdata = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; run_en = 0; sig_in = 16'h1234; drain_ready = 0;
    cfg_every = '0; cfg_hwm = FLW'(6); idle_in();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sig_out == sig_in, "R1", sig_out, sig_in);
    chk(!host_rvalid && !drain_valid && !stall_req, "R1",
        {host_rvalid, drain_valid, stall_req}, 0);
    rst_n = 1;
    // R7: rewind with empty history
    host(2'b10, 0, '0); step();
    // R5 R6: three captures then rewind at several offsets
    idle_in(); run_en = 1;
    for (int i = 0; i < 3; i++) begin sig_in = DW'(16'hA0 + i); step(); end
    run_en = 0;
    for (int k = 0; k < 4; k++) begin host(2'b10, k, '0); step(); end
    // R4 live read
    sig_in = 16'h5A5A; host(2'b00, 0, '0); step();
    // R8 R9: fill FIFO with ready low, overflow dropped
    idle_in(); run_en = 1;
    for (int i = 0; i < 8; i++) begin sig_in = DW'(16'hB0 + i); step(); end
    run_en = 0; drain_ready = 1;
    for (int i = 0; i < 9; i++) step();
    drain_ready = 0;
    // R3: override held while run_en low, used once, then released
    host(2'b01, 0, 16'hBEEF); sig_in = 16'h0101; step();
    idle_in();
    for (int i = 0; i < 3; i++) step();
    run_en = 1; step();
    step(); run_en = 0;
    // R10: no-op request, then confirm nothing staged
    host(2'b11, 3, 16'hDEAD); step();
    idle_in(); step();
    // R5: period of 3 enabled cycles with gaps
    cfg_every = DV'(2); drain_ready = 1;
    for (int i = 0; i < 12; i++) begin
      run_en = (i % 4 != 3); sig_in = DW'(16'hC0 + i); step();
    end
    // R7 large offset after history wrap
    cfg_every = '0; run_en = 1;
    for (int i = 0; i < 20; i++) begin sig_in = DW'(16'hD0 + i); step(); end
    run_en = 0;
    host(2'b10, 15, '0); step();
    host(2'b10, 16, '0); step();
    host(2'b10, 31, '0); step();
    idle_in();
    // random mix
    for (int i = 0; i < 1500; i++) begin
      run_en = ($urandom % 4) != 0;
      sig_in = DW'($urandom);
      drain_ready = $urandom % 2;
      if (i % 200 == 0) begin
        cfg_every = DV'($urandom % 4);
        cfg_hwm = FLW'($urandom % (FD + 1));
      end
      if ($urandom % 3 == 0) host(2'($urandom), int'($urandom % 32), DW'($urandom));
      else idle_in();
      step();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule